// File: doc/BRIEF.md
# Serial-video retimer control and output steering

This block is the control, status and output-steering logic of a serial-video retimer. It picks what each of two differential output pairs carries: retimed data, the raw input data, the recovered clock or a muted level. It also produces a lock indicator and a standard-rate indicator, both registered on the 27 MHz reference clock. The clock-recovery loop, the analog buffers and the rate detector are outside it. Their results reach the block as two asynchronous flags: the loop is locked, and the detected rate is the supported 270 Mbps.

The mode controls are forced bypass, an active-low mute and a clock/data select for the second pair. They are plain level inputs. Each is captured once per reference clock. The two flags pass through a synchronizer before anything uses them. Steering between the bit-rate inputs and the pairs is combinational, so a data bit reaches the pins with no added delay. All pins are plain levels. No pin carries a valid/ready handshake, so there is no back-pressure to obey.

Top module: `rclk_ctl_top`

## Requirements
- R1: When the captured forced-bypass control is high, both pairs that carry data show `raw_data` (the true bit equals `raw_data`, the complement is its inverse), and `lock_ind` is low whatever the loop state.
- R2: When forced bypass is low, the block bypasses retiming whenever the synchronized locked flag or the synchronized rate flag is low, and the data pairs show `raw_data`. When both flags are high, the data pairs show `rt_data`.
- R3: When the captured `mute_n` is low, both pairs are muted, whatever the bypass state or the select.
- R4: A muted pair drives its true bit 0 and its complement bit 1. No pair ever shows the same level on its true and complement bits.
- R5: With `sel_clk` captured high, pair B carries `rec_clk` (true bit equals `rec_clk`). With it low, pair B carries the same data as pair A.
- R6: When pair B is in clock mode and any bypass is active, forced or automatic, pair B is muted.
- R7: `std_rate_ind` is high only while `lock_ind` is high and the synchronized rate flag is high.
- R8: `std_rate_ind` rises one reference clock after `lock_ind` rises. It falls in the same cycle that `lock_ind` falls, so it is never high while `lock_ind` is low.
- R9: `lock_ind` is high exactly when the synchronized locked flag is high and forced bypass is low. A change on `pll_locked` reaches `lock_ind` at the third rising clock edge after the change.
- R10: While `rst_n` is low (synchronous, active low), `lock_ind` and `std_rate_ind` are 0, forced bypass is inactive, mute is released and pair B is in data mode. The synchronized flags are also held low in reset, so both pairs then carry `raw_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| force_byp | input | 1 | Forced bypass control, active high |
| mute_n | input | 1 | Output mute, active low |
| sel_clk | input | 1 | Pair B mode: 1 = recovered clock, 0 = data |
| pll_locked | input | 1 | Asynchronous loop-locked flag |
| rate_ok | input | 1 | Asynchronous supported-rate flag |
| rt_data | input | 1 | Retimed data bit |
| raw_data | input | 1 | Raw input data bit |
| rec_clk | input | 1 | Recovered clock bit |
| out_a_p | output | 1 | Pair A, true bit |
| out_a_n | output | 1 | Pair A, complement bit |
| out_b_p | output | 1 | Pair B, true bit |
| out_b_n | output | 1 | Pair B, complement bit |
| lock_ind | output | 1 | Lock indicator, registered |
| std_rate_ind | output | 1 | Standard-rate indicator, registered |

## Verification
The bench sweeps all 256 combinations of the eight mode, flag and bit inputs. It waits for them to settle and compares every output with a model computed in the bench. This sweep separates the priority of mute over forced bypass over automatic bypass. It also separates raw data from retimed data and clock mode from data mode, because the raw, retimed and clock bits are varied independently, so choosing the wrong source gives a visible mismatch. Separate timed sequences step the locked flag up and down and sample every cycle. They check the three-edge synchronizer latency and the one-cycle lag of the rate indicator on a rise. They also check that the rate indicator falls in the same cycle as the lock indicator.

// File: rtl/rclk_ctl_pkg.sv
package rclk_ctl_pkg;

  localparam int NUM_PAIRS = 2;

  typedef enum logic [1:0] {
    SRC_MUTE  = 2'd0,
    SRC_DATA  = 2'd1,
    SRC_CLOCK = 2'd2
  } src_e;

  typedef struct packed {
    logic p;
    logic n;
  } pair_t;

  function automatic pair_t drive_pair(input src_e src, input logic dbit, input logic cbit);
    pair_t r;
    case (src)
      SRC_DATA:  begin r.p = dbit; r.n = ~dbit; end
      SRC_CLOCK: begin r.p = cbit; r.n = ~cbit; end
      default:   begin r.p = 1'b0; r.n = 1'b1; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rclk_sync.sv
module rclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rclk_ctl_regs.sv
module rclk_ctl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic force_byp,
  input  logic mute_n,
  input  logic sel_clk,
  output logic force_q,
  output logic mute_q,
  output logic sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      force_q <= 1'b0;
      mute_q  <= 1'b1;
      sel_q   <= 1'b0;
    end else begin
      force_q <= force_byp;
      mute_q  <= mute_n;
      sel_q   <= sel_clk;
    end
  end

  p_reset_defaults_r10: assert property (@(posedge clk)
    !rst_n |=> (!force_q && mute_q && !sel_q));
endmodule

// File: rtl/rclk_status.sv
module rclk_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_q,
  input  logic pll_locked,
  input  logic rate_ok,
  output logic lock_q,
  output logic sd_q,
  output logic auto_byp
);
  logic lk_s, rt_s, lock_d;

  rclk_sync #(.STAGES(SYNC_STAGES)) u_sync_lock (
    .clk(clk), .rst_n(rst_n), .d(pll_locked), .q(lk_s));
  rclk_sync #(.STAGES(SYNC_STAGES)) u_sync_rate (
    .clk(clk), .rst_n(rst_n), .d(rate_ok), .q(rt_s));

  assign lock_d   = lk_s & ~force_q;
  assign auto_byp = ~(lk_s & rt_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      lock_q <= lock_d;
      sd_q   <= lock_d ? (lock_q & rt_s) : 1'b0;
    end
  end

  p_force_kills_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    force_q |=> !lock_q);
  p_sd_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |-> !sd_q);
  p_sd_rise_lags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_q) |-> $past(lock_q));
  p_sd_needs_rate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_q |-> $past(rt_s));
  p_lock_follows_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> $past(lk_s));
endmodule

// File: rtl/rclk_steer.sv
module rclk_steer
  import rclk_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  force_q,
  input  logic  auto_byp,
  input  logic  mute_q,
  input  logic  sel_q,
  input  logic  rt_data,
  input  logic  raw_data,
  input  logic  rec_clk,
  output pair_t pairs [NUM_PAIRS]
);
  logic bypass, dbit;
  src_e src [NUM_PAIRS];

  assign bypass = force_q | auto_byp;
  assign dbit   = bypass ? raw_data : rt_data;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    if (g == 0) begin : g_data_only
      always_comb begin
        if (!mute_q) src[g] = SRC_MUTE;
        else         src[g] = SRC_DATA;
      end
    end else begin : g_selectable
      always_comb begin
        if (!mute_q)          src[g] = SRC_MUTE;
        else if (!sel_q)      src[g] = SRC_DATA;
        else if (bypass)      src[g] = SRC_MUTE;
        else                  src[g] = SRC_CLOCK;
      end
    end
    assign pairs[g] = drive_pair(src[g], dbit, rec_clk);

    p_pair_differs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pairs[g].p != pairs[g].n);
    p_mute_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mute_q |-> (pairs[g].p == 1'b0 && pairs[g].n == 1'b1));
  end

  p_clock_muted_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && bypass) |-> (pairs[NUM_PAIRS-1].p == 1'b0 && pairs[NUM_PAIRS-1].n == 1'b1));
  p_force_raw_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (force_q && mute_q) |-> (pairs[0].p == raw_data));
endmodule

// File: rtl/rclk_ctl_top.sv
module rclk_ctl_top
  import rclk_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_byp,
  input  logic mute_n,
  input  logic sel_clk,
  input  logic pll_locked,
  input  logic rate_ok,
  input  logic rt_data,
  input  logic raw_data,
  input  logic rec_clk,
  output logic out_a_p,
  output logic out_a_n,
  output logic out_b_p,
  output logic out_b_n,
  output logic lock_ind,
  output logic std_rate_ind
);
  logic  force_q, mute_q, sel_q, auto_byp;
  pair_t pairs [NUM_PAIRS];

  rclk_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .force_byp(force_byp), .mute_n(mute_n),
    .sel_clk(sel_clk), .force_q(force_q), .mute_q(mute_q), .sel_q(sel_q));

  rclk_status #(.SYNC_STAGES(SYNC_STAGES)) u_status (
    .clk(clk), .rst_n(rst_n), .force_q(force_q), .pll_locked(pll_locked),
    .rate_ok(rate_ok), .lock_q(lock_ind), .sd_q(std_rate_ind), .auto_byp(auto_byp));

  rclk_steer u_steer (
    .clk(clk), .rst_n(rst_n), .force_q(force_q), .auto_byp(auto_byp),
    .mute_q(mute_q), .sel_q(sel_q), .rt_data(rt_data), .raw_data(raw_data),
    .rec_clk(rec_clk), .pairs(pairs));

  assign out_a_p = pairs[0].p;
  assign out_a_n = pairs[0].n;
  assign out_b_p = pairs[1].p;
  assign out_b_n = pairs[1].n;

  p_sd_implies_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    std_rate_ind |-> lock_ind);
endmodule

// File: tb/rclk_ctl_top_bench.sv
module rclk_ctl_top_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic force_byp = 0, mute_n = 1, sel_clk = 0, pll_locked = 0, rate_ok = 0;
  logic rt_data = 0, raw_data = 0, rec_clk = 0;
  logic out_a_p, out_a_n, out_b_p, out_b_n, lock_ind, std_rate_ind;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rclk_ctl_top u_rclk_ctl_top (.*);

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_sample(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state
    raw_data = 1; rt_data = 0;
    edge_sample(3);
    check("R10 lock_ind in reset", lock_ind, 1'b0);
    check("R10 std_rate_ind in reset", std_rate_ind, 1'b0);
    check("R10 pair A raw in reset", out_a_p, 1'b1);
    check("R10 pair B data mode in reset", out_b_p, 1'b1);
    check("R10 pair B complement in reset", out_b_n, 1'b0);
    @(negedge clk); rst_n = 1;

    // R9/R8: lock and rate timing
    @(negedge clk); pll_locked = 1; rate_ok = 1;
    edge_sample(1); check("R9 lock after 1 edge", lock_ind, 1'b0);
    edge_sample(1); check("R9 lock after 2 edges", lock_ind, 1'b0);
    edge_sample(1); check("R9 lock after 3 edges", lock_ind, 1'b1);
    check("R8 sd lags lock rise", std_rate_ind, 1'b0);
    edge_sample(1); check("R8 sd one cycle after lock", std_rate_ind, 1'b1);
    check("R7 sd with lock and rate", std_rate_ind, 1'b1);
    @(negedge clk); pll_locked = 0;
    edge_sample(2); check("R9 lock held 2 edges", lock_ind, 1'b1);
    edge_sample(1); check("R9 lock falls 3rd edge", lock_ind, 1'b0);
    check("R8 sd falls with lock", std_rate_ind, 1'b0);
    // rate drop while locked
    @(negedge clk); pll_locked = 1; rate_ok = 1;
    edge_sample(5);
    @(negedge clk); rate_ok = 0;
    edge_sample(4); check("R7 sd low when rate unsupported", std_rate_ind, 1'b0);
    check("R9 lock stays with rate low", lock_ind, 1'b1);
    // R1: forced bypass drops lock
    @(negedge clk); force_byp = 1;
    edge_sample(2); check("R1 lock low under force", lock_ind, 1'b0);
    check("R8 sd low under force", std_rate_ind, 1'b0);

    // exhaustive sweep
    for (int i = 0; i < 256; i++) begin
      logic f, m, s, l, r, rt, rw, rc;
      logic byp, d, e_lock, e_sd, e_ap, e_an, e_bp, e_bn;
      {f, m, s, l, r, rt, rw, rc} = i[7:0];
      @(negedge clk);
      force_byp = f; mute_n = m; sel_clk = s; pll_locked = l; rate_ok = r;
      rt_data = rt; raw_data = rw; rec_clk = rc;
      edge_sample(5);
      byp = f | ~l | ~r;
      d = byp ? rw : rt;
      e_lock = l & ~f;
      e_sd = e_lock & r;
      if (!m) begin e_ap = 0; e_an = 1; e_bp = 0; e_bn = 1; end
      else begin
        e_ap = d; e_an = ~d;
        if (!s) begin e_bp = d; e_bn = ~d; end
        else if (byp) begin e_bp = 0; e_bn = 1; end
        else begin e_bp = rc; e_bn = ~rc; end
      end
      check(f ? "R1 lock sweep" : "R9 lock sweep", lock_ind, e_lock);
      check("R7 sd sweep", std_rate_ind, e_sd);
      check(!m ? "R3 pair A mute sweep" : (f ? "R1 pair A sweep" : "R2 pair A sweep"), out_a_p, e_ap);
      check(!m ? "R4 pair A complement sweep" : "R2 pair A complement sweep", out_a_n, e_an);
      check(!m ? "R3 pair B mute sweep" : (s ? (byp ? "R6 pair B sweep" : "R5 pair B clock sweep") : "R5 pair B data sweep"), out_b_p, e_bp);
      check("R4 pair B complement sweep", out_b_n, e_bn);
    end
    finish_run();
  end
endmodule